// File: doc/BRIEF.md
# Two-Phase Request Capture Queue

This block sits between a processor-side request port and a memory controller. The processor presents requests over one 8-bit bus, with a valid strobe, a read/write flag and a phase flag. A read needs only one beat, which carries the address. A write needs two consecutive beats: an address beat (phase 0) and then a data beat (phase 1). The block turns each complete request into one entry of a small in-order FIFO. An entry holds the type, the address and the write data. The oldest entry is offered to the downstream controller, which removes it with a pop strobe.

A busy flag tells the processor when it may not start a new request. Busy is raised when the queue is full. It is also raised when one slot is free and that slot is already reserved for a write whose data beat is still to come. A write whose address beat is not followed by its data beat is discarded and reported with a one-cycle error pulse. A data beat with no address beat before it is treated the same way.

Top module: `reqcap_queue`

## Requirements
- R1: After reset, out_valid, busy and seq_err are all 0.
- R2: A beat with in_valid=1 and in_rw=0 is a complete read, whatever the value of in_phase. It is enqueued as an entry with out_rw=0, out_addr equal to in_data and out_wdata=0. The entry is visible at the outputs in the cycle after the beat is sampled, and seq_err stays 0.
- R3: A write is an address beat (in_valid=1, in_rw=1, in_phase=0, in_data=address) followed in the very next cycle by a data beat (in_valid=1, in_rw=1, in_phase=1, in_data=write data). Nothing is enqueued after the address beat alone. After the data beat, one entry with out_rw=1 and the captured address and data is enqueued.
- R4: Entries leave strictly oldest first. While out_valid=1 and out_pop=0, the head entry does not change.
- R5: When out_valid=1, out_pop removes the head entry at that clock edge. When the queue is empty, out_pop has no effect, even if a request is enqueued at the same edge.
- R6: busy=1 whenever all DEPTH slots (default 4) are occupied.
- R7: busy=1 when DEPTH-1 slots are occupied and a write address beat is waiting for its data beat. The data beat that follows an accepted address beat is always accepted.
- R8: If the cycle after a write address beat does not carry a phase-1 write beat, the pending address is dropped and seq_err is 1 for exactly one cycle, in the cycle after that beat. That beat is then handled as a fresh beat: a read is enqueued, and a new address beat starts a new write.
- R9: A phase-1 write beat with no pending address enqueues nothing. It makes seq_err 1 for exactly one cycle, in the cycle after the beat.
- R10: A request that completes at the same edge as a pop on a full queue is accepted. The occupancy stays at DEPTH, and the new entry joins the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A beat is present this cycle |
| in_rw | input | 1 | 0 = read, 1 = write |
| in_phase | input | 1 | Write beat kind: 0 = address, 1 = data; ignored for reads |
| in_data | input | 8 | Address or write data |
| busy | output | 1 | No new request may be started |
| seq_err | output | 1 | One-cycle pulse when a write beat sequence is broken |
| out_valid | output | 1 | The head entry is valid |
| out_pop | input | 1 | Removes the head entry |
| out_rw | output | 1 | Type of the head entry |
| out_addr | output | 8 | Address of the head entry |
| out_wdata | output | 8 | Write data of the head entry (0 for reads) |

## Verification
The assertions assume the processor never completes a request into a full queue unless the consumer pops at the same edge. Under that assumption, the increment checks on occupancy and the busy reservation checks can hold. The stimulus keeps to this rule: it waits for busy to drop before starting each request. It breaks the rule only in the R10 case, where it raises out_pop a cycle early so that the pop lands on the same edge as the new read. The broken-write and orphan-data cases are driven on purpose. They are not violations, because the block defines its response to them.

// File: rtl/reqcap_pkg.sv
package reqcap_pkg;

  parameter int unsigned BUS_W = 8;

  typedef struct packed {
    logic             rw;
    logic [BUS_W-1:0] addr;
    logic [BUS_W-1:0] wdata;
  } req_entry_t;

  typedef enum logic [1:0] {
    BEAT_NONE,
    BEAT_READ,
    BEAT_WADDR,
    BEAT_WDATA
  } beat_kind_e;

  function automatic beat_kind_e classify_beat(logic v, logic rw, logic ph);
    if (!v)       return BEAT_NONE;
    else if (!rw) return BEAT_READ;
    else if (!ph) return BEAT_WADDR;
    else          return BEAT_WDATA;
  endfunction

  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  function automatic logic busy_rule(int unsigned occ, int unsigned depth, logic pending);
    return (occ >= depth) || (pending && (occ + 1 >= depth));
  endfunction

endpackage

// File: rtl/beat_assembler.sv
module beat_assembler
  import reqcap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_rw,
  input  logic             in_phase,
  input  logic [BUS_W-1:0] in_data,
  output logic             push,
  output req_entry_t       push_entry,
  output logic             pending,
  output logic             err
);

  logic             pend_q, pend_d;
  logic [BUS_W-1:0] addr_q, addr_d;
  beat_kind_e       kind;

  always_comb begin
    kind       = classify_beat(in_valid, in_rw, in_phase);
    push       = 1'b0;
    push_entry = '0;
    err        = 1'b0;
    pend_d     = pend_q;
    addr_d     = addr_q;
    if (pend_q && kind == BEAT_WDATA) begin
      push             = 1'b1;
      push_entry.rw    = 1'b1;
      push_entry.addr  = addr_q;
      push_entry.wdata = in_data;
      pend_d           = 1'b0;
    end else begin
      if (pend_q) begin
        err    = 1'b1;
        pend_d = 1'b0;
      end
      case (kind)
        BEAT_READ: begin
          push            = 1'b1;
          push_entry.addr = in_data;
        end
        BEAT_WADDR: begin
          pend_d = 1'b1;
          addr_d = in_data;
        end
        BEAT_WDATA: err = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
    end else begin
      pend_q <= pend_d;
      addr_q <= addr_d;
    end
  end

  assign pending = pend_q;

endmodule

// File: rtl/entry_fifo.sv
module entry_fifo
  import reqcap_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  req_entry_t       push_entry,
  input  logic             pop,
  output req_entry_t       head,
  output logic             head_valid,
  output logic [CNT_W-1:0] occ
);

  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

  req_entry_t       slot_q [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic             do_push, do_pop;

  assign do_pop  = pop && (occ != '0);
  assign do_push = push && ((occ != FULL_C) || do_pop);

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slot_q[s] <= '0;
      else if (do_push && wr_ptr == PTR_W'(s)) slot_q[s] <= push_entry;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      occ    <= '0;
    end else begin
      if (do_push) wr_ptr <= PTR_W'(wrap_inc(32'(wr_ptr), DEPTH));
      if (do_pop)  rd_ptr <= PTR_W'(wrap_inc(32'(rd_ptr), DEPTH));
      if (do_push && !do_pop)      occ <= occ + CNT_W'(1);
      else if (do_pop && !do_push) occ <= occ - CNT_W'(1);
    end
  end

  assign head       = slot_q[rd_ptr];
  assign head_valid = (occ != '0);

endmodule

// File: rtl/reqcap_queue.sv
module reqcap_queue
  import reqcap_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_rw,
  input  logic             in_phase,
  input  logic [BUS_W-1:0] in_data,
  output logic             busy,
  output logic             seq_err,
  output logic             out_valid,
  input  logic             out_pop,
  output logic             out_rw,
  output logic [BUS_W-1:0] out_addr,
  output logic [BUS_W-1:0] out_wdata
);

  logic             asm_push;
  req_entry_t       asm_entry;
  logic             pend_w;
  logic             asm_err;
  req_entry_t       head_w;
  logic [CNT_W-1:0] occ_w;

  beat_assembler u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_rw      (in_rw),
    .in_phase   (in_phase),
    .in_data    (in_data),
    .push       (asm_push),
    .push_entry (asm_entry),
    .pending    (pend_w),
    .err        (asm_err)
  );

  entry_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (asm_push),
    .push_entry (asm_entry),
    .pop        (out_pop),
    .head       (head_w),
    .head_valid (out_valid),
    .occ        (occ_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) seq_err <= 1'b0;
    else        seq_err <= asm_err;
  end

  assign busy      = busy_rule(32'(occ_w), DEPTH, pend_w);
  assign out_rw    = head_w.rw;
  assign out_addr  = head_w.addr;
  assign out_wdata = head_w.wdata;

endmodule

// File: rtl/reqcap_queue_chk.sv
module reqcap_queue_chk #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_rw,
  input logic             in_phase,
  input logic             busy,
  input logic             seq_err,
  input logic             out_valid,
  input logic             out_pop,
  input logic             out_rw,
  input logic [7:0]       out_addr,
  input logic [7:0]       out_wdata,
  input logic [CNT_W-1:0] occ,
  input logic             pend,
  input logic             asm_push
);

  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(DEPTH - 1);

  logic data_beat;
  assign data_beat = in_valid && in_rw && in_phase;

  a_r6_busy_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    occ == FULL_C |-> busy);

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == FULL_C && asm_push) |-> out_pop);

  a_r7_busy_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && occ == LAST_C) |-> busy);

  a_r4_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_pop) |=> (out_valid && $stable({out_rw, out_addr, out_wdata})));

  a_r5_pop_removes: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_pop && !asm_push) |=> occ == $past(occ) - CNT_W'(1));

  a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && out_pop && !asm_push) |=> !out_valid);

  a_r3_write_enqueued: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && data_beat && !out_pop) |=> occ == $past(occ) + CNT_W'(1));

  a_r8_broken_write: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !data_beat) |=> seq_err);

  a_r9_orphan_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && data_beat) |=> seq_err);

  a_r10_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == FULL_C && out_pop && asm_push) |=> occ == FULL_C);

endmodule

bind reqcap_queue reqcap_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_rw     (in_rw),
  .in_phase  (in_phase),
  .busy      (busy),
  .seq_err   (seq_err),
  .out_valid (out_valid),
  .out_pop   (out_pop),
  .out_rw    (out_rw),
  .out_addr  (out_addr),
  .out_wdata (out_wdata),
  .occ       (occ_w),
  .pend      (pend_w),
  .asm_push  (asm_push)
);

// File: tb/reqcap_queue_tb.sv
`timescale 1ns/100ps
module reqcap_queue_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_rw = 1'b0, in_phase = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       busy, seq_err, out_valid, out_rw;
  logic [7:0] out_addr, out_wdata;
  logic       mon_pop = 1'b0, extra_pop = 1'b0, pop_en = 1'b0;
  logic       out_pop;

  int errors = 0;
  int checks = 0;
  logic [16:0] exp_q[$];

  assign out_pop = mon_pop | extra_pop;

  always #2.5 clk = ~clk;

  reqcap_queue u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_rw(in_rw),
    .in_phase(in_phase), .in_data(in_data), .busy(busy), .seq_err(seq_err),
    .out_valid(out_valid), .out_pop(out_pop), .out_rw(out_rw),
    .out_addr(out_addr), .out_wdata(out_wdata)
  );

  task automatic check(input logic ok, input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: compares the head with the scoreboard and pops it at the next edge.
  always @(posedge clk) begin
    #1;
    if (!rst_n) mon_pop = 1'b0;
    else if (pop_en && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected entry", {out_rw, out_addr, out_wdata}, 17'h0);
      end else begin
        check({out_rw, out_addr, out_wdata} == exp_q[0], "R4 order/content",
              {out_rw, out_addr, out_wdata}, exp_q[0]);
        void'(exp_q.pop_front());
      end
      mon_pop = 1'b1;
    end else mon_pop = 1'b0;
  end

  task automatic send_read(input logic [7:0] a, input logic ph);
    @(negedge clk);
    while (busy) @(negedge clk);
    in_valid = 1'b1; in_rw = 1'b0; in_phase = ph; in_data = a;
    exp_q.push_back({1'b0, a, 8'h00});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    while (busy) @(negedge clk);
    in_valid = 1'b1; in_rw = 1'b1; in_phase = 1'b0; in_data = a;
    @(negedge clk);
    in_phase = 1'b1; in_data = d;
    exp_q.push_back({1'b1, a, d});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    pop_en = 1'b1;
    for (int i = 0; i < 100 && (exp_q.size() != 0 || out_valid); i++) @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0 && !out_valid, "R4 drained", {16'h0, out_valid}, 17'h0);
    pop_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!out_valid && !busy && !seq_err, "R1 reset", {14'h0, out_valid, busy, seq_err}, 17'h0);

    // R3: address beat alone enqueues nothing; data beat completes the write
    @(negedge clk);
    in_valid = 1'b1; in_rw = 1'b1; in_phase = 1'b0; in_data = 8'h22;
    @(negedge clk);
    check(!out_valid, "R3 no entry after address beat", {16'h0, out_valid}, 17'h0);
    in_phase = 1'b1; in_data = 8'h5A;
    exp_q.push_back({1'b1, 8'h22, 8'h5A});
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && {out_rw, out_addr, out_wdata} == {1'b1, 8'h22, 8'h5A}, "R3 write entry",
          {out_rw, out_addr, out_wdata}, {1'b1, 8'h22, 8'h5A});
    drain();

    // R5: pop on empty queue is ignored, same-edge read still lands (R2)
    @(negedge clk);
    extra_pop = 1'b1;
    in_valid = 1'b1; in_rw = 1'b0; in_phase = 1'b1; in_data = 8'h11;
    exp_q.push_back({1'b0, 8'h11, 8'h00});
    @(negedge clk);
    extra_pop = 1'b0; in_valid = 1'b0;
    check(out_valid, "R5 empty pop ignored", {16'h0, out_valid}, 17'h1);
    check({out_rw, out_addr, out_wdata} == {1'b0, 8'h11, 8'h00}, "R2 read entry phase ignored",
          {out_rw, out_addr, out_wdata}, {1'b0, 8'h11, 8'h00});
    check(!seq_err, "R2 no error on read", {16'h0, seq_err}, 17'h0);
    drain();

    // R4: mixed stream, oldest first
    pop_en = 1'b1;
    for (int k = 0; k < 10; k++) begin
      if (k % 3 == 1) send_write(8'(8'h40 + k), 8'(8'hC0 ^ k));
      else            send_read(8'(8'h80 + k), 1'(k));
    end
    drain();

    // R9: orphan data beat
    @(negedge clk);
    in_valid = 1'b1; in_rw = 1'b1; in_phase = 1'b1; in_data = 8'h99;
    @(negedge clk);
    in_valid = 1'b0;
    check(seq_err, "R9 orphan error pulse", {16'h0, seq_err}, 17'h1);
    @(negedge clk);
    check(!seq_err, "R9 pulse one cycle", {16'h0, seq_err}, 17'h0);
    check(!out_valid, "R9 nothing enqueued", {16'h0, out_valid}, 17'h0);

    // R8: address followed by a read
    @(negedge clk);
    in_valid = 1'b1; in_rw = 1'b1; in_phase = 1'b0; in_data = 8'h33;
    @(negedge clk);
    in_rw = 1'b0; in_data = 8'h44;
    exp_q.push_back({1'b0, 8'h44, 8'h00});
    @(negedge clk);
    in_valid = 1'b0;
    check(seq_err, "R8 broken write error", {16'h0, seq_err}, 17'h1);
    check(out_valid && {out_rw, out_addr, out_wdata} == {1'b0, 8'h44, 8'h00}, "R8 read kept",
          {out_rw, out_addr, out_wdata}, {1'b0, 8'h44, 8'h00});
    @(negedge clk);
    check(!seq_err, "R8 pulse one cycle", {16'h0, seq_err}, 17'h0);
    drain();

    // R8: address followed by an idle cycle
    @(negedge clk);
    in_valid = 1'b1; in_rw = 1'b1; in_phase = 1'b0; in_data = 8'h35;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(seq_err, "R8 missing data beat error", {16'h0, seq_err}, 17'h1);
    @(negedge clk);
    check(!seq_err && !out_valid, "R8 address dropped", {15'h0, seq_err, out_valid}, 17'h0);

    // R8: address followed by a new address restarts the write
    @(negedge clk);
    in_valid = 1'b1; in_rw = 1'b1; in_phase = 1'b0; in_data = 8'h55;
    @(negedge clk);
    in_data = 8'h66;
    @(negedge clk);
    in_phase = 1'b1; in_data = 8'h77;
    exp_q.push_back({1'b1, 8'h66, 8'h77});
    check(seq_err, "R8 restart error", {16'h0, seq_err}, 17'h1);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && {out_rw, out_addr, out_wdata} == {1'b1, 8'h66, 8'h77}, "R8 restarted write",
          {out_rw, out_addr, out_wdata}, {1'b1, 8'h66, 8'h77});
    drain();

    // R6 then R10
    for (int k = 0; k < 4; k++) begin
      check(!busy, "R6 not busy below full", {16'h0, busy}, 17'h0);
      send_read(8'(8'hA0 + k), 1'b0);
    end
    check(busy, "R6 busy when full", {16'h0, busy}, 17'h1);
    pop_en = 1'b1;
    @(negedge clk);
    in_valid = 1'b1; in_rw = 1'b0; in_phase = 1'b0; in_data = 8'hAB;
    exp_q.push_back({1'b0, 8'hAB, 8'h00});
    @(negedge clk);
    in_valid = 1'b0;
    check(busy, "R10 occupancy held at full", {16'h0, busy}, 17'h1);
    drain();

    // R7: reserved last slot
    for (int k = 0; k < 3; k++) send_read(8'(8'hD0 + k), 1'b1);
    check(!busy, "R7 not busy with one free slot", {16'h0, busy}, 17'h0);
    @(negedge clk);
    in_valid = 1'b1; in_rw = 1'b1; in_phase = 1'b0; in_data = 8'hE1;
    @(negedge clk);
    check(busy, "R7 busy while write pending", {16'h0, busy}, 17'h1);
    in_phase = 1'b1; in_data = 8'hE2;
    exp_q.push_back({1'b1, 8'hE1, 8'hE2});
    @(negedge clk);
    in_valid = 1'b0;
    check(busy && !seq_err, "R7 data beat accepted", {15'h0, busy, seq_err}, 17'h2);
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule